// File: doc/BRIEF.md
# Paged Firmware Download Sequencer

This block copies a firmware image into a microcontroller code window with no software involved, then runs the two-step start-up handshake. The image arrives as a byte stream with a valid/ready handshake. A pulse on `start` latches the image length, a padding switch and a flat-mode switch. The block raises a download-enable level and walks the image: a page-select write before each page, 32-bit writes within the page, and single-byte writes for a short tail. It then drops the enable and clears the status byte that follows it.

After the copy, the sequencer polls a checksum-reported bit, checking once per cycle up to a retry limit. On success it issues one control write that marks the firmware ready and clears the init-ready bit. It then polls init-ready with a fixed idle gap between polls. The run ends with a one-cycle `done`. `error` stays set until the next accepted start; `timeout` tells a lost handshake apart from an image that does not fit.

Top module: `fwdl_seq`

## Requirements
- R1: `dl_en` rises on the clock edge that accepts `start`. Every window write occurs while `dl_en` is high. `dl_en` is low in the cycle of the single `stat_clr_we` pulse that ends the copy.
- R2: With `pad_en` high, a length that is not a multiple of 4 is rounded up with zero bytes, and an aligned length is left as is. Padding bytes are never taken from the stream, so exactly `img_len` bytes are consumed.
- R3: In paged mode, before the first write of each page, `page_sel_we` pulses. `page_sel_byte[2:0]` carries the page index, counted from 0, and `page_sel_byte[7:3]` equals `sel_keep`. A partial last page gets the index after the last full page.
- R4: In paged mode, if the padded length holds more than MAX_PAGES full pages, the run ends with `done`, `error`=1 and `timeout`=0. No write is made, no byte is consumed and `dl_en` stays low.
- R5: While at least 4 bytes remain, the block makes a 32-bit write (`bus_dword`) of 4 stream bytes. The first byte goes in bits 7:0. The address is WIN_BASE plus the byte offset within the page.
- R6: Remaining 1 to 3 bytes are written one at a time (`bus_byte`, data in bits 7:0, upper bits zero) at the next offsets.
- R7: `cksum_rpt` is checked once per cycle, starting the cycle after `stat_clr_we`. If it is not seen within RETRY checks, `done` arrives RETRY+1 cycles after `stat_clr_we`, with `error`=1 and `timeout`=1.
- R8: When the checksum is seen, `fw_rdy_we` pulses for one cycle. `init_rdy` is then checked RETRY times, with POLL_GAP idle cycles between checks. If it never rises, `done` comes 2+(RETRY-1)*(POLL_GAP+1) cycles after `fw_rdy_we`, with `error`=1 and `timeout`=1.
- R9: `done` is high for exactly one cycle. `error` and `timeout` hold their value after `done` until the next accepted `start` clears them. A run that completes both handshakes ends with both flags at 0.
- R10: With `legacy_mode` high there are no page-select writes and no page limit. Addresses run as WIN_BASE plus the byte offset from the start of the image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a download (accepted when idle) |
| legacy_mode | input | 1 | Flat single-block copy without paging |
| pad_en | input | 1 | Round length up to a multiple of 4 with zeros |
| img_len | input | LEN_W | Image length in bytes |
| img_valid | input | 1 | Stream byte available |
| img_data | input | 8 | Stream byte |
| img_ready | output | 1 | Stream byte taken at this edge when valid |
| bus_dword | output | 1 | 32-bit window write strobe |
| bus_byte | output | 1 | Single-byte window write strobe |
| bus_addr | output | ADDR_W | Window write address |
| bus_wdata | output | 32 | Window write data |
| sel_keep | input | 5 | Current upper bits of the page-select byte |
| page_sel_we | output | 1 | Page-select byte write strobe |
| page_sel_byte | output | 8 | Page-select byte value |
| dl_en | output | 1 | Download-enable level |
| stat_clr_we | output | 1 | Write of zero to the status byte after the enable |
| fw_rdy_we | output | 1 | Set firmware-ready and clear init-ready in one write |
| cksum_rpt | input | 1 | Checksum-reported status bit |
| init_rdy | input | 1 | Init-ready status bit |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Run failed (held) |
| timeout | output | 1 | Failure was a handshake timeout (held) |

## Verification
`dl_en` and `error` are sampled one cycle after the edge that takes `start`. In the overflow case `done` is also due in that cycle. Each window write costs a dispatch cycle, one fill cycle per byte and one write cycle, and each page adds one page-select cycle. Strobes are therefore captured at falling edges into an event log and compared in order with a list built in the bench, rather than being tied to fixed cycles. The two handshake timeouts are checked as exact cycle distances: from `stat_clr_we` to `done` (RETRY+1) and from `fw_rdy_we` to `done` (2+(RETRY-1)*(POLL_GAP+1)).

// File: rtl/fwdl_pkg.sv
package fwdl_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_DISP, S_PSEL, S_FILL, S_WRITE,
    S_OFF, S_CK, S_RDY, S_IPOLL, S_GAP, S_FIN
  } fwdl_state_e;

  // length after optional rounding up to a 4-byte multiple
  function automatic logic [31:0] pad_to_word(input logic [31:0] n, input logic en);
    return en ? ((n + 32'd3) & ~32'd3) : n;
  endfunction

  // bytes in the next window write: a word while 4 remain, else a byte
  function automatic logic [2:0] chunk_bytes(input logic [31:0] total, input logic [31:0] pos);
    return ((total - pos) >= 32'd4) ? 3'd4 : 3'd1;
  endfunction

  // number of complete pages in a length
  function automatic logic [31:0] full_pages(input logic [31:0] total, input int page_bytes);
    return total / 32'(page_bytes);
  endfunction

endpackage

// File: rtl/fwdl_tick_ctr.sv
module fwdl_tick_ctr #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_last
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + W'(1);
  end

  assign at_last = (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/fwdl_packer.sv
module fwdl_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        take,
  input  logic [7:0]  byte_in,
  output logic [31:0] word,
  output logic [2:0]  cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      cnt  <= '0;
    end else if (clr) begin
      word <= '0;
      cnt  <= '0;
    end else if (take) begin
      word[{cnt[1:0], 3'b000} +: 8] <= byte_in;
      cnt <= cnt + 3'd1;
    end
  end
endmodule

// File: rtl/fwdl_seq.sv
module fwdl_seq
  import fwdl_pkg::*;
#(
  parameter int PAGE_BYTES = 4096,
  parameter int MAX_PAGES  = 4,
  parameter int LEN_W      = 16,
  parameter int ADDR_W     = 16,
  parameter int WIN_BASE   = 'h1000,
  parameter int RETRY      = 1000,
  parameter int POLL_GAP   = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              legacy_mode,
  input  logic              pad_en,
  input  logic [LEN_W-1:0]  img_len,
  input  logic              img_valid,
  input  logic [7:0]        img_data,
  output logic              img_ready,
  output logic              bus_dword,
  output logic              bus_byte,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [4:0]        sel_keep,
  output logic              page_sel_we,
  output logic [7:0]        page_sel_byte,
  output logic              dl_en,
  output logic              stat_clr_we,
  output logic              fw_rdy_we,
  input  logic              cksum_rpt,
  input  logic              init_rdy,
  output logic              done,
  output logic              error,
  output logic              timeout
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int TOT_W = LEN_W + 1;

  fwdl_state_e      state;
  logic [LEN_W-1:0] len_q;
  logic [TOT_W-1:0] total_q, pos_q;
  logic             legacy_q, dl_en_q, err_q, tmo_q;

  // start-time geometry
  logic [31:0] tot_in;
  logic        ovf_in;
  assign tot_in = pad_to_word(32'(img_len), pad_en);
  assign ovf_in = !legacy_mode && (full_pages(tot_in, PAGE_BYTES) > 32'(MAX_PAGES));

  // copy-phase events
  logic [31:0]      word;
  logic [2:0]       fcnt, chunk;
  logic [TOT_W-1:0] cur_idx;
  logic             need_stream, take, fill_last, page_start;
  logic [7:0]       fill_byte;
  logic [OFF_W-1:0] page_off;
  logic [2:0]       page_idx;

  assign chunk       = chunk_bytes(32'(total_q), 32'(pos_q));
  assign cur_idx     = pos_q + TOT_W'(fcnt);
  assign need_stream = cur_idx < TOT_W'(len_q);
  assign take        = (state == S_FILL) && (!need_stream || img_valid);
  assign fill_byte   = need_stream ? img_data : 8'h00;
  assign fill_last   = take && ((fcnt + 3'd1) == chunk);
  assign page_off    = pos_q[OFF_W-1:0];
  assign page_idx    = 3'(pos_q >> OFF_W);
  assign page_start  = !legacy_q && (page_off == '0);

  // handshake-phase events
  logic ck_poll, init_poll, rty_last, gap_last;
  assign ck_poll   = (state == S_CK);
  assign init_poll = (state == S_IPOLL);

  fwdl_packer u_pack (
    .clk(clk), .rst_n(rst_n), .clr(state == S_DISP), .take(take),
    .byte_in(fill_byte), .word(word), .cnt(fcnt)
  );

  fwdl_tick_ctr #(.LIMIT(RETRY)) u_retry (
    .clk(clk), .rst_n(rst_n),
    .clr((state == S_OFF) || (state == S_RDY)),
    .inc((ck_poll && !cksum_rpt) || (init_poll && !init_rdy)),
    .at_last(rty_last)
  );

  fwdl_tick_ctr #(.LIMIT(POLL_GAP)) u_gap (
    .clk(clk), .rst_n(rst_n), .clr(init_poll), .inc(state == S_GAP),
    .at_last(gap_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      len_q    <= '0;
      total_q  <= '0;
      pos_q    <= '0;
      legacy_q <= 1'b0;
      dl_en_q  <= 1'b0;
      err_q    <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          legacy_q <= legacy_mode;
          len_q    <= img_len;
          total_q  <= TOT_W'(tot_in);
          pos_q    <= '0;
          tmo_q    <= 1'b0;
          if (ovf_in) begin
            err_q <= 1'b1;
            state <= S_FIN;
          end else begin
            err_q   <= 1'b0;
            dl_en_q <= 1'b1;
            state   <= S_DISP;
          end
        end
        S_DISP: begin
          if (pos_q == total_q) begin
            dl_en_q <= 1'b0;
            state   <= S_OFF;
          end else if (page_start) begin
            state <= S_PSEL;
          end else begin
            state <= S_FILL;
          end
        end
        S_PSEL:  state <= S_FILL;
        S_FILL:  if (fill_last) state <= S_WRITE;
        S_WRITE: begin
          pos_q <= pos_q + TOT_W'(chunk);
          state <= S_DISP;
        end
        S_OFF: state <= S_CK;
        S_CK: begin
          if (cksum_rpt) state <= S_RDY;
          else if (rty_last) begin
            err_q <= 1'b1;
            tmo_q <= 1'b1;
            state <= S_FIN;
          end
        end
        S_RDY: state <= S_IPOLL;
        S_IPOLL: begin
          if (init_rdy) state <= S_FIN;
          else if (rty_last) begin
            err_q <= 1'b1;
            tmo_q <= 1'b1;
            state <= S_FIN;
          end else state <= S_GAP;
        end
        S_GAP: if (gap_last) state <= S_IPOLL;
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign img_ready     = (state == S_FILL) && need_stream;
  assign bus_dword     = (state == S_WRITE) && (chunk == 3'd4);
  assign bus_byte      = (state == S_WRITE) && (chunk == 3'd1);
  assign bus_addr      = legacy_q ? (ADDR_W'(WIN_BASE) + ADDR_W'(pos_q))
                                  : (ADDR_W'(WIN_BASE) + ADDR_W'(page_off));
  assign bus_wdata     = (chunk == 3'd4) ? word : {24'h0, word[7:0]};
  assign page_sel_we   = (state == S_PSEL);
  assign page_sel_byte = {sel_keep, page_idx};
  assign dl_en         = dl_en_q;
  assign stat_clr_we   = (state == S_OFF);
  assign fw_rdy_we     = (state == S_RDY);
  assign done          = (state == S_FIN);
  assign error         = err_q;
  assign timeout       = tmo_q;
endmodule

// File: rtl/fwdl_seq_chk.sv
module fwdl_seq_chk #(
  parameter int ADDR_W   = 16,
  parameter int WIN_BASE = 'h1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              bus_dword,
  input logic              bus_byte,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [4:0]        sel_keep,
  input logic              page_sel_we,
  input logic [7:0]        page_sel_byte,
  input logic              dl_en,
  input logic              stat_clr_we,
  input logic              fw_rdy_we,
  input logic              cksum_rpt,
  input logic              done,
  input logic              error,
  input logic              timeout,
  input logic              legacy_q,
  input logic              ck_poll,
  input logic              init_poll
);
  localparam logic [1:0] BASE_LO = 2'(WIN_BASE);

  // R1
  wr_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dword || bus_byte) |-> dl_en);
  // R1
  en_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr_we |-> !dl_en);
  // R3
  sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_sel_we |-> (page_sel_byte[7:3] == sel_keep));
  // R5
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dword |-> (bus_addr[1:0] == BASE_LO));
  // R8
  rdy_after_ck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fw_rdy_we |-> $past(ck_poll && cksum_rpt));
  // R8
  poll_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_poll |=> !init_poll);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);
  // R7
  tmo_is_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> error);
  // R10
  flat_no_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_q |-> !page_sel_we);
  // R1
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_dword, bus_byte, page_sel_we, stat_clr_we, fw_rdy_we}));
endmodule

bind fwdl_seq fwdl_seq_chk #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .bus_dword(bus_dword), .bus_byte(bus_byte), .bus_addr(bus_addr),
  .sel_keep(sel_keep), .page_sel_we(page_sel_we), .page_sel_byte(page_sel_byte),
  .dl_en(dl_en), .stat_clr_we(stat_clr_we), .fw_rdy_we(fw_rdy_we),
  .cksum_rpt(cksum_rpt), .done(done), .error(error), .timeout(timeout),
  .legacy_q(legacy_q), .ck_poll(ck_poll), .init_poll(init_poll)
);

// File: tb/fwdl_seq_tb.sv
module fwdl_seq_tb;
  localparam int PG = 16, MAXP = 4, RTY = 6, GAP = 3, BASE = 'h0100;
  localparam logic [4:0] KEEP = 5'b10101;

  // {len[9:0], pad, legacy, cksum_ok, init_ok, stall}
  localparam logic [14:0] VECS [11] = '{
    {10'd40, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {10'd37, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    {10'd37, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {10'd23, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    {10'd80, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {10'd64, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {10'd10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {10'd10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {10'd3,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {10'd0,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {10'd70, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 0, rst_n = 0, start = 0, legacy_mode = 0, pad_en = 0;
  logic [9:0] img_len = '0;
  logic img_valid = 0, img_ready;
  logic [7:0] img_data;
  logic bus_dword, bus_byte, page_sel_we, dl_en, stat_clr_we, fw_rdy_we;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [7:0] page_sel_byte;
  logic cksum_rpt = 0, init_rdy = 0, done, error, timeout;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, seed = 0, sent = 0;
  bit pend = 0, stall = 0, cks_ok = 0, ini_ok = 0;
  bit clr_seen = 0, rdy_seen = 0, done_seen = 0;
  int init_cnt = 0, clr_cyc = 0, rdy_cyc = 0, done_cyc = 0;
  int ev_n = 0, ex_n = 0;
  int          ev_k [64];
  logic [31:0] ev_a [64], ev_d [64];
  int          ex_k [64];
  logic [31:0] ex_a [64], ex_d [64];

  always #4 clk = ~clk;

  function automatic logic [7:0] img_byte(int i, int s);
    return 8'(i * 7 + s * 13 + 1);
  endfunction

  assign img_data = img_byte(sent, seed);

  fwdl_seq #(.PAGE_BYTES(PG), .MAX_PAGES(MAXP), .LEN_W(10), .ADDR_W(16),
             .WIN_BASE(BASE), .RETRY(RTY), .POLL_GAP(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .legacy_mode(legacy_mode),
    .pad_en(pad_en), .img_len(img_len), .img_valid(img_valid),
    .img_data(img_data), .img_ready(img_ready), .bus_dword(bus_dword),
    .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .sel_keep(KEEP), .page_sel_we(page_sel_we), .page_sel_byte(page_sel_byte),
    .dl_en(dl_en), .stat_clr_we(stat_clr_we), .fw_rdy_we(fw_rdy_we),
    .cksum_rpt(cksum_rpt), .init_rdy(init_rdy), .done(done),
    .error(error), .timeout(timeout)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic push_ev(input int k, input logic [31:0] a, input logic [31:0] d);
    if (ev_n < 64) begin
      ev_k[ev_n] = k; ev_a[ev_n] = a; ev_d[ev_n] = d;
    end
    ev_n++;
  endtask

  // monitor, stream source and status model, all at falling edges
  always @(negedge clk) begin
    cyc++;
    if (start) begin
      ev_n = 0; sent = 0; pend = 0; clr_seen = 0; rdy_seen = 0;
      done_seen = 0; init_cnt = 0; cksum_rpt = 0; init_rdy = 0;
    end else begin
      if (pend) sent++;
      if (page_sel_we) push_ev(1, 0, 32'(page_sel_byte));
      if (bus_dword)   push_ev(2, 32'(bus_addr), bus_wdata);
      if (bus_byte)    push_ev(3, 32'(bus_addr), bus_wdata);
      if (stat_clr_we) begin push_ev(4, 0, 0); clr_seen = 1; clr_cyc = cyc; end
      if (fw_rdy_we)   begin push_ev(5, 0, 0); rdy_seen = 1; rdy_cyc = cyc; init_cnt = 0; end
      else if (rdy_seen) init_cnt++;
      if (done && !done_seen) begin done_seen = 1; done_cyc = cyc; end
      cksum_rpt = cks_ok && clr_seen;
      init_rdy  = ini_ok && rdy_seen && (init_cnt >= 4);
      img_valid = stall ? ((cyc % 3) != 0) : 1'b1;
      pend = img_valid && img_ready;
    end
  end

  function automatic void add_ex(int k, logic [31:0] a, logic [31:0] d);
    if (ex_n < 64) begin
      ex_k[ex_n] = k; ex_a[ex_n] = a; ex_d[ex_n] = d;
    end
    ex_n++;
  endfunction

  task automatic run_vec(input int vi);
    logic [14:0] v;
    int len, total, pos;
    bit pad, leg, ovf, exp_err, exp_tmo;
    logic [31:0] w;
    v = VECS[vi];
    len = int'(v[14:5]); pad = v[4]; leg = v[3];
    cks_ok = v[2]; ini_ok = v[1]; stall = v[0];
    seed = vi + 3;
    total = pad ? ((len + 3) / 4) * 4 : len;
    ovf = !leg && ((total / PG) > MAXP);
    ex_n = 0;
    if (!ovf) begin
      pos = 0;
      while (pos < total) begin
        if (!leg && (pos % PG) == 0) add_ex(1, 0, {24'h0, KEEP, 3'(pos / PG)});
        if (total - pos >= 4) begin
          w = 0;
          for (int b = 0; b < 4; b++)
            if (pos + b < len) w[8*b +: 8] = img_byte(pos + b, seed);
          add_ex(2, 32'(BASE + (leg ? pos : pos % PG)), w);
          pos += 4;
        end else begin
          add_ex(3, 32'(BASE + (leg ? pos : pos % PG)), {24'h0, img_byte(pos, seed)});
          pos += 1;
        end
      end
      add_ex(4, 0, 0);
      if (cks_ok) add_ex(5, 0, 0);
    end
    exp_err = ovf || !cks_ok || !ini_ok;
    exp_tmo = !ovf && (!cks_ok || !ini_ok);

    @(posedge clk); #1;
    legacy_mode = leg; pad_en = pad; img_len = 10'(len); start = 1;
    @(posedge clk); #1;
    start = 0;
    if (ovf) begin
      // R4: overflow ends at once
      chk(done && error && !timeout && !dl_en, "R4 overflow flags", {done, error, timeout, dl_en}, 4'b1100);
    end else begin
      // R1: enable up one cycle after start; R9: flags cleared by start
      chk(dl_en == 1'b1, "R1 enable after start", dl_en, 1);
      chk(error == 1'b0, "R9 error cleared by start", error, 0);
    end
    for (int t = 0; t < 2000 && !done_seen; t++) @(posedge clk);
    #1;
    chk(done_seen, "R9 done reached", done_seen, 1);
    repeat (3) @(posedge clk);
    #1;
    // R9: done is a pulse, flags held
    chk(!done && error == exp_err && timeout == exp_tmo, "R9 held flags",
        {done, error, timeout}, {1'b0, exp_err, exp_tmo});
    // R2: padding not drawn from stream; R4 consumes nothing
    chk(sent == (ovf ? 0 : len), "R2 bytes consumed", sent, ovf ? 0 : len);
    chk(ev_n == ex_n, "R3 R5 R6 event count", ev_n, ex_n);
    begin
      int bad = -1;
      for (int e = 0; e < ex_n && e < ev_n && e < 64; e++)
        if (bad < 0 && (ev_k[e] != ex_k[e] || ev_a[e] !== ex_a[e] || ev_d[e] !== ex_d[e])) bad = e;
      if (bad >= 0)
        chk(0, leg ? "R10 flat write sequence" : "R3 R5 R6 paged write sequence",
            {ev_k[bad][7:0], ev_a[bad][15:0], ev_d[bad]}, {ex_k[bad][7:0], ex_a[bad][15:0], ex_d[bad]});
      else
        chk(1, "R5 write sequence", 0, 0);
    end
    if (!ovf && !cks_ok)
      chk(done_cyc - clr_cyc == RTY + 1, "R7 checksum timeout latency", done_cyc - clr_cyc, RTY + 1);
    if (!ovf && cks_ok && !ini_ok)
      chk(done_cyc - rdy_cyc == 2 + (RTY - 1) * (GAP + 1), "R8 init timeout latency",
          done_cyc - rdy_cyc, 2 + (RTY - 1) * (GAP + 1));
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // reset state
    chk({done, error, timeout, dl_en, img_ready, bus_dword, bus_byte, page_sel_we} == 8'h0,
        "R9 reset outputs", {done, error, timeout, dl_en}, 0);
    rst_n = 1;
    repeat (2) @(posedge clk);
    #1;
    chk(!done && !error && !dl_en, "R1 idle after reset", {done, error, dl_en}, 0);
    for (int i = 0; i < 11; i++) run_vec(i);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule